// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date in binary-coded decimal. Seven cascaded counters hold seconds, minutes, hours, day of week, day of month, month and a two-digit year. A sub-second strobe drives an internal prescaler. Every `TICKS_PER_SEC` strobes the seconds advance by one, and each wrap carries into the next field. The day-of-month limit follows the month and the leap status of the year.

Software-style access goes through a write port that loads one field per cycle and a capture-then-read port. A capture pulse copies every field into a snapshot bank in a single cycle. Individual bytes are then read from that bank, so a multi-byte read can never mix values from before and after a rollover. A set of registered carry pulses, one per field, lets a neighbouring alarm or interrupt unit react to rollovers. A control bit selects 12-hour or 24-hour hour coding.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x12 (midnight in 12-hour coding), day of week 0x00, day of month 0x01, month 0x01, year 0x00, and the control byte reads 0x00. Before the first capture the snapshot bank reads 0x00 at every address, and `carry_o` is zero.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. Seconds advance once for every `TICKS_PER_SEC` strobes on `tick_i`. Seconds at 0x59 wrap to 0x00 and advance the minutes, and minutes at 0x59 wrap to 0x00 and advance the hour.
- R3: With control bit 0 (address 7) set to 1, the block uses 24-hour coding. The hour counts 0x00 to 0x23 in BCD, and 0x23 wraps to 0x00 with a day carry.
- R4: With control bit 0 cleared, the block uses 12-hour coding, and hour bit 5 marks PM. The sequence is 0x12 (midnight), 0x01 to 0x11, 0x32 (noon), 0x21 to 0x31, then back to 0x12 with a day carry.
- R5: The day-of-week counter advances on each day carry and wraps from 0x06 to 0x00.
- R6: The day of month counts from 0x01. After 0x28, 0x29, 0x30 or 0x31 it wraps to 0x01 and advances the month. February uses 0x28 (or 0x29 in a leap year). Months 0x04, 0x06, 0x09 and 0x11 use 0x30. All other months use 0x31.
- R7: A two-digit year is a leap year when its value is divisible by four. This includes 0x00.
- R8: A write with `wr_en_i` loads `wr_data_i` into the field at `wr_addr_i`. The addresses are: 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 control. A written field takes the written value even when an advance falls in the same cycle. A seconds write also clears the prescaler and cancels that cycle's advance, so the next advance comes a full `TICKS_PER_SEC` strobes later.
- R9: Writing the control bit changes only the coding of later hour steps. It does not convert an hour value that is already stored.
- R10: A cycle with `snap_i` high copies all eight bytes into the snapshot bank at the next edge. The copy holds the values from before any advance in that same cycle. The bank holds its contents until the next capture, and `rd_data_o` shows the byte selected by `rd_addr_i`.
- R11: `carry_o` bit k pulses for one cycle, in the cycle after the edge on which field k wrapped. The bit order is 0 seconds, 1 minutes, 2 hour (day end), 3 day of week, 4 day of month, 5 month, 6 year.
- R12: The month wraps from 0x12 to 0x01 and advances the year, and the year wraps from 0x99 to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sub-second strobe, one cycle per pulse |
| wr_en_i | input | 1 | Field write enable |
| wr_addr_i | input | 3 | Field address for writes |
| wr_data_i | input | 8 | Write data (BCD) |
| snap_i | input | 1 | Capture all fields into the snapshot bank |
| rd_addr_i | input | 3 | Snapshot byte select |
| rd_data_o | output | 8 | Selected snapshot byte |
| carry_o | output | 7 | Registered per-field rollover pulses |

## Verification
The hardest case to reach from the ports is a capture that lands on the same edge as a full rollover, from 23:59:59 on 31 December of year 99 to midnight of year 00. Reaching it by counting strobes would take far too long. The bench instead loads every field directly and writes the seconds last, which clears the prescaler to a known phase. It then issues exactly `TICKS_PER_SEC`-1 strobes and raises the capture and the final strobe in the same cycle. The month-length and leap-year boundaries are reached the same way: the bench loads the time to the last second of a day and applies one more second of strobes.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_CNT    = 7;
  localparam int unsigned NUM_FIELDS = NUM_CNT + 1;
  localparam int unsigned ADDR_W     = $clog2(NUM_FIELDS);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_MDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CTRL = 7;

  typedef logic [FIELD_W-1:0] bcd_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by four: even tens -> ones 0/4/8, odd tens -> ones 2/6
  function automatic logic year_leap(bcd_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd_t month_len(bcd_t m, logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_min(int k);
    return (k == IDX_MDAY || k == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t field_rst(int k);
    case (k)
      IDX_HOUR:          return 8'h12;
      IDX_MDAY, IDX_MON: return 8'h01;
      default:           return 8'h00;
    endcase
  endfunction

  function automatic bcd_t field_mask(int k);
    case (k)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR:         return 8'h3F;
      IDX_WDAY:         return 8'h07;
      IDX_MDAY:         return 8'h3F;
      IDX_MON:          return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/bcd_tk_presc.sv
module bcd_tk_presc #(
  parameter int unsigned TPS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam int unsigned CW = (TPS > 1) ? $clog2(TPS) : 1;

  if (TPS <= 1) begin : g_direct
    assign adv_o = tick_i & ~clr_i;
  end else begin : g_count
    localparam logic [CW-1:0] LAST = CW'(TPS - 1);
    logic [CW-1:0] cnt_q;

    assign adv_o = tick_i & ~clr_i & (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_tk_ctr.sv
module bcd_tk_ctr
  import bcd_tk_pkg::*;
#(
  parameter bcd_t MIN  = 8'h00,
  parameter bcd_t RST  = 8'h00,
  parameter bcd_t MASK = 8'hFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  bcd_t hi_i,
  output bcd_t val_o,
  output logic at_max_o
);
  bcd_t val_q, val_d;

  assign at_max_o = (val_q >= hi_i);
  assign val_o    = val_q;

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = ld_val_i & MASK;
    else if (inc_i) val_d = at_max_o ? MIN : bcd_inc(val_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RST;
    else         val_q <= val_d;
  end
endmodule

// File: rtl/bcd_tk_hour.sv
module bcd_tk_hour
  import bcd_tk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode24_i,
  input  logic inc_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  input  bcd_t hi_i,
  output bcd_t val_o,
  output logic at_max_o
);
  bcd_t hour_q, hour_d, h12, h12_inc;
  logic pm;

  assign pm      = hour_q[5];
  assign h12     = {3'b000, hour_q[4:0]};
  assign h12_inc = bcd_inc(h12);
  assign val_o   = hour_q;

  // 24h: day ends at hi_i; 12h: day ends at PM11
  assign at_max_o = mode24_i ? (hour_q >= hi_i) : (pm && h12 == 8'h11);

  always_comb begin
    hour_d = hour_q;
    if (ld_i) begin
      hour_d = ld_val_i & 8'h3F;
    end else if (inc_i) begin
      if (mode24_i)            hour_d = at_max_o ? 8'h00 : bcd_inc(hour_q);
      else if (h12 == 8'h12)   hour_d = {2'b00, pm, 5'h01};
      else if (h12 == 8'h11)   hour_d = {2'b00, ~pm, 5'h12};
      else                     hour_d = {2'b00, pm, h12_inc[4:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hour_q <= 8'h12;
    else         hour_q <= hour_d;
  end
endmodule

// File: rtl/bcd_tk_snap.sv
module bcd_tk_snap
  import bcd_tk_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cap_i,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   fields_i,
  input  logic [ADDR_W-1:0]                    sel_i,
  output logic [FIELD_W-1:0]                   data_o,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   snap_o
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= fields_i;
  end

  assign data_o = snap_q[sel_i];
  assign snap_o = snap_q;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcd_tk_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic               snap_i,
  input  logic [2:0]         rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic [6:0]         carry_o
);
  logic [NUM_CNT-1:0][FIELD_W-1:0] val;
  bcd_t                            hi [NUM_CNT];
  logic [NUM_CNT-1:0]              inc, ld, at_max, wrap;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields, snap_vals;
  logic                            adv, sec_wr, mode_q;
  logic [NUM_CNT-1:0]              carry_q;

  always_comb begin
    for (int k = 0; k < int'(NUM_CNT); k++)
      ld[k] = wr_en_i && (wr_addr_i == ADDR_W'(k));
  end
  assign sec_wr = ld[IDX_SEC];

  bcd_tk_presc #(.TPS(TICKS_PER_SEC)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (sec_wr),
    .adv_o (adv)
  );

  always_comb begin
    hi[IDX_SEC]  = 8'h59;
    hi[IDX_MIN]  = 8'h59;
    hi[IDX_HOUR] = 8'h23;
    hi[IDX_WDAY] = 8'h06;
    hi[IDX_MDAY] = month_len(val[IDX_MON], year_leap(val[IDX_YEAR]));
    hi[IDX_MON]  = 8'h12;
    hi[IDX_YEAR] = 8'h99;
  end

  // carry ripple from registered at-limit flags
  always_comb begin
    logic c;
    c = adv;         inc[IDX_SEC]  = c;
    c &= at_max[IDX_SEC];  inc[IDX_MIN]  = c;
    c &= at_max[IDX_MIN];  inc[IDX_HOUR] = c;
    c &= at_max[IDX_HOUR]; inc[IDX_WDAY] = c; inc[IDX_MDAY] = c;
    c &= at_max[IDX_MDAY]; inc[IDX_MON]  = c;
    c &= at_max[IDX_MON];  inc[IDX_YEAR] = c;
    wrap = inc & at_max;
  end

  for (genvar k = 0; k < int'(NUM_CNT); k++) begin : g_fld
    if (k == IDX_HOUR) begin : g_hour
      bcd_tk_hour u_hour (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode24_i(mode_q),
        .inc_i   (inc[k]),
        .ld_i    (ld[k]),
        .ld_val_i(wr_data_i),
        .hi_i    (hi[k]),
        .val_o   (val[k]),
        .at_max_o(at_max[k])
      );
    end else begin : g_cnt
      bcd_tk_ctr #(
        .MIN (field_min(k)),
        .RST (field_rst(k)),
        .MASK(field_mask(k))
      ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (inc[k]),
        .ld_i    (ld[k]),
        .ld_val_i(wr_data_i),
        .hi_i    (hi[k]),
        .val_o   (val[k]),
        .at_max_o(at_max[k])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      carry_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_W'(IDX_CTRL)) mode_q <= wr_data_i[0];
      carry_q <= wrap;
    end
  end
  assign carry_o = carry_q;

  assign fields = {{7'b0, mode_q}, val};

  bcd_tk_snap u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (snap_i),
    .fields_i(fields),
    .sel_i   (rd_addr_i),
    .data_o  (rd_data_o),
    .snap_o  (snap_vals)
  );
endmodule

// File: rtl/bcd_tk_checker.sv
module bcd_tk_checker (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [2:0]      wr_addr_i,
  input logic [7:0]      wr_data_i,
  input logic            snap_i,
  input logic [6:0]      carry_i,
  input logic [6:0][7:0] val_i,
  input logic            mode_i,
  input logic [7:0][7:0] snap_q_i
);
  a_r2_sec_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[0] |-> val_i[0] == 8'h00);

  a_r11_min_needs_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[1] |-> carry_i[0]);

  a_r3_hour24_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[2] && !$past(wr_en_i) && $past(mode_i) |-> val_i[2] == 8'h00);

  a_r4_hour12_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[2] && !$past(wr_en_i) && !$past(mode_i) |-> val_i[2] == 8'h12);

  a_r5_wday_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[3] && !$past(wr_en_i) |-> val_i[3] == 8'h00);

  a_r12_month_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i[5] && !$past(wr_en_i) |-> val_i[5] == 8'h01);

  a_r8_sec_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 3'd0 |=> val_i[0] == ($past(wr_data_i) & 8'h7F));

  a_r10_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q_i));
endmodule

bind bcd_timekeeper bcd_tk_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .snap_i   (snap_i),
  .carry_i  (carry_o),
  .val_i    (val),
  .mode_i   (mode_q),
  .snap_q_i (snap_vals)
);

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
  localparam int TPS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, snap = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [6:0] carry;

  always #5 clk = ~clk;

  bcd_timekeeper #(.TICKS_PER_SEC(TPS)) u_bcd_timekeeper (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .snap_i(snap),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .carry_o(carry)
  );

  typedef struct { logic [2:0] addr; logic [7:0] exp; string req; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against snapshot reads
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        rd_addr = it.addr;
        #1;
        check(it.req, rd_data, it.exp);
      end
    end
  end

  task automatic push(logic [2:0] a, logic [7:0] e, string req);
    item_t it;
    it.addr = a; it.exp = e; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic take_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                         logic [7:0] md, logic [7:0] mo, logic [7:0] y);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd); wr(3'd4, md); wr(3'd5, mo); wr(3'd6, y);
    wr(3'd0, s);
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic advance(output logic [6:0] c);
    for (int i = 0; i < TPS; i++) one_tick();
    #1 c = carry;
  endtask

  task automatic expect_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                             logic [7:0] md, logic [7:0] mo, logic [7:0] y, string req);
    take_snap();
    push(3'd0, s, req); push(3'd1, m, req); push(3'd2, h, req); push(3'd3, wd, req);
    push(3'd4, md, req); push(3'd5, mo, req); push(3'd6, y, req);
    drain();
  endtask

  task automatic day_roll(logic [7:0] md, logic [7:0] mo, logic [7:0] y,
                          logic [7:0] e_md, logic [7:0] e_mo, logic [7:0] e_y, string req);
    logic [6:0] c;
    set_all(8'h59, 8'h59, 8'h23, 8'h00, md, mo, y);
    advance(c);
    take_snap();
    push(3'd4, e_md, req); push(3'd5, e_mo, req); push(3'd6, e_y, req);
    drain();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: snapshot bank empty, carries idle, defaults after capture
    #1 check("R1 carry", {1'b0, carry}, 8'h00);
    push(3'd0, 8'h00, "R1 bank"); push(3'd2, 8'h00, "R1 bank");
    drain();
    expect_time(8'h00, 8'h00, 8'h12, 8'h00, 8'h01, 8'h01, 8'h00, "R1");
    push(3'd7, 8'h00, "R1 ctrl"); drain();

    // R2: one second of strobes
    advance(c);
    check("R2 carry", {1'b0, c}, 8'h00);
    expect_time(8'h01, 8'h00, 8'h12, 8'h00, 8'h01, 8'h01, 8'h00, "R2");

    // R2: seconds wrap into minutes
    set_all(8'h59, 8'h00, 8'h12, 8'h00, 8'h01, 8'h01, 8'h00);
    advance(c);
    check("R11 sec carry", {1'b0, c}, 8'h01);
    expect_time(8'h00, 8'h01, 8'h12, 8'h00, 8'h01, 8'h01, 8'h00, "R2");

    // R8: seconds write clears prescaler
    one_tick();
    wr(3'd0, 8'h10);
    one_tick();
    take_snap(); push(3'd0, 8'h10, "R8 no early advance"); drain();
    one_tick();
    take_snap(); push(3'd0, 8'h11, "R8 full second"); drain();

    // R3/R5/R12/R11: full rollover in 24h mode
    wr(3'd7, 8'h01);
    set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    advance(c);
    check("R11 all carries", {1'b0, c}, 8'h7F);
    expect_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R3 R5 R12");
    push(3'd7, 8'h01, "R3 ctrl"); drain();

    // R3: decade step
    set_all(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    expect_time(8'h00, 8'h00, 8'h10, 8'h02, 8'h10, 8'h03, 8'h21, "R3 decade");

    // R9: mode change keeps stored hour
    wr(3'd2, 8'h15);
    wr(3'd7, 8'h00);
    take_snap();
    push(3'd2, 8'h15, "R9 hour kept"); push(3'd7, 8'h00, "R9 ctrl"); drain();

    // R4: 12h sequence
    set_all(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    check("R4 no day carry", {1'b0, c}, 8'h03);
    take_snap(); push(3'd2, 8'h32, "R4 AM11->PM12"); drain();
    set_all(8'h59, 8'h59, 8'h32, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    take_snap(); push(3'd2, 8'h21, "R4 PM12->PM1"); drain();
    set_all(8'h59, 8'h59, 8'h29, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    take_snap(); push(3'd2, 8'h30, "R4 PM9->PM10"); drain();
    set_all(8'h59, 8'h59, 8'h12, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    take_snap(); push(3'd2, 8'h01, "R4 AM12->AM1"); drain();
    set_all(8'h59, 8'h59, 8'h31, 8'h02, 8'h10, 8'h03, 8'h21);
    advance(c);
    check("R4 day carry", {1'b0, c}, 8'h07);
    expect_time(8'h00, 8'h00, 8'h12, 8'h03, 8'h11, 8'h03, 8'h21, "R4 PM11->AM12");

    // R5: week wrap in 12h mode
    set_all(8'h59, 8'h59, 8'h31, 8'h06, 8'h10, 8'h03, 8'h21);
    advance(c);
    check("R5 wday carry", {1'b0, c}, 8'h0F);
    take_snap(); push(3'd3, 8'h00, "R5 wrap"); drain();

    // R6/R7/R12: month lengths and leap years (24h)
    wr(3'd7, 8'h01);
    day_roll(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, 8'h23, "R6 april");
    day_roll(8'h30, 8'h01, 8'h23, 8'h31, 8'h01, 8'h23, "R6 january");
    day_roll(8'h30, 8'h11, 8'h23, 8'h01, 8'h12, 8'h23, "R6 november");
    day_roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R6 feb common");
    day_roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "R7 feb 24");
    day_roll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "R7 feb 29 end");
    day_roll(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "R7 year 00");
    day_roll(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10, "R7 year 10");
    day_roll(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12, "R7 year 12");
    day_roll(8'h31, 8'h12, 8'h23, 8'h01, 8'h01, 8'h24, "R12 year step");

    // R10: capture on the rollover edge
    set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    for (int i = 0; i < TPS - 1; i++) one_tick();
    @(negedge clk); snap = 1'b1; tick = 1'b1;
    @(negedge clk); snap = 1'b0; tick = 1'b0;
    push(3'd0, 8'h59, "R10 old"); push(3'd1, 8'h59, "R10 old");
    push(3'd2, 8'h23, "R10 old"); push(3'd3, 8'h06, "R10 old");
    push(3'd4, 8'h31, "R10 old"); push(3'd5, 8'h12, "R10 old");
    push(3'd6, 8'h99, "R10 old");
    drain();
    expect_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R10 new");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule